// File: doc/BRIEF.md
# Twin-Accumulator Fractional Multiply-Accumulate Unit

This block performs multiply-accumulate on signed 16-bit fractional words with a single multiplier and two 40-bit accumulators. A program can therefore compute two FIR outputs side by side over one shared memory. Each convolution step multiplies a memory word by a register-file word and adds the product into the accumulator that the index input selects. In the same step the block returns the memory word so that it can be written back into the register. The next step then reuses that word and does not have to read memory again.

The product has 2 integer and 30 fraction bits. Eight guard bits widen it to a 10.30 accumulator. A readout instruction first adds a rounding constant to the selected accumulator, then saturates the sum to a 16-bit 1.15 word. The accumulator itself keeps its value. All results appear on one registered write-back output one cycle after the instruction.

Top module: `twin_acc_mac`

## Requirements
- R1: After reset both accumulators hold zero and `wb_word_o` is 0x0000.
- R2: Op code 1 (convolve, memory on port A) adds the signed product `mem_word_i`×`rf_word_i` to the selected accumulator. The product is sign-extended from 32 to 40 bits. On the next cycle `wb_word_o` equals the `mem_word_i` that was applied.
- R3: Op code 3 (clear) sets the selected accumulator to zero.
- R4: Op code 0 (no operation) and the unused codes 5, 6 and 7 leave both accumulators and `wb_word_o` unchanged.
- R5: An accumulator that `acc_sel_i` does not select keeps its value under every op code.
- R6: Op code 2 (convolve, memory on port B) accumulates exactly as op code 1 does and also forwards `mem_word_i` to `wb_word_o`. Only the multiplier port that receives the memory word is different.
- R7: Op code 4 (readout) puts the rounded and saturated value of the selected accumulator on `wb_word_o` on the next cycle. The accumulator is not modified.
- R8: Readout adds 0x0000004000 to the accumulator modulo 2^40. If bits 39..30 of the sum are all equal, the result is bits 30..15 of the sum.
- R9: If bits 39..30 of the rounded sum are not all equal, readout gives 0x8000 when bit 39 is 1 and 0x7FFF otherwise.
- R10: Accumulation wraps modulo 2^40 and does not saturate inside the accumulator.
- R11: Clear and no-operation codes leave `wb_word_o` at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Op code: 0 none, 1 convolve A, 2 convolve B, 3 clear, 4 readout |
| acc_sel_i | input | 1 | Accumulator index |
| rf_word_i | input | 16 | Register-file operand, signed 1.15 |
| mem_word_i | input | 16 | Memory operand, signed 1.15 |
| wb_word_o | output | 16 | Registered write-back word to the register file |

## Verification
The assertions assume that `op_i` and `acc_sel_i` are steady at every rising edge. They also assume that the unused op codes behave like the no-operation code, and that an unselected accumulator stays out of every update. The bench changes its inputs only one time unit after each rising edge, and it applies codes 5 to 7 only in the hold checks. Runs of full-scale operands take the accumulator through its 2^39 sign boundary and back to zero. Single products with chosen values sit at each rounding and saturation threshold.

// File: rtl/twin_mac_pkg.sv
package twin_mac_pkg;
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_CONV_A = 3'd1,
        OP_CONV_B = 3'd2,
        OP_CLEAR  = 3'd3,
        OP_READ   = 3'd4
    } mac_op_e;
endpackage

// File: rtl/frac_mul.sv
module frac_mul #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    output logic [2*DW-1:0] p_o
);
    always_comb begin
        p_o = $signed(a_i) * $signed(b_i);
    end
endmodule

// File: rtl/acc_readout.sv
module acc_readout #(
    parameter int DW = 16,
    parameter int GW = 8
) (
    input  logic [2*DW+GW-1:0] acc_i,
    output logic [DW-1:0]      word_o
);
    localparam int AW = 2*DW + GW;
    localparam int FB = 2*DW - 2;
    localparam logic [AW-1:0] RND = AW'(1) << (FB - DW);

    logic [AW-1:0]   sum;
    logic [AW-FB-1:0] head;

    always_comb begin
        sum  = acc_i + RND;
        head = sum[AW-1:FB];
        if ((&head) || !(|head)) begin
            word_o = sum[FB:FB-DW+1];
        end else if (sum[AW-1]) begin
            word_o = {1'b1, {(DW-1){1'b0}}};
        end else begin
            word_o = {1'b0, {(DW-1){1'b1}}};
        end
    end
endmodule

// File: rtl/twin_acc_mac.sv
module twin_acc_mac
    import twin_mac_pkg::*;
#(
    parameter int DW   = 16,
    parameter int GW   = 8,
    parameter int NACC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                op_i,
    input  logic [$clog2(NACC)-1:0]   acc_sel_i,
    input  logic [DW-1:0]             rf_word_i,
    input  logic [DW-1:0]             mem_word_i,
    output logic [DW-1:0]             wb_word_o
);
    localparam int AW = 2*DW + GW;
    localparam int PW = 2*DW;

    typedef struct packed {
        logic [NACC-1:0][AW-1:0] acc;
        logic [DW-1:0]           wb;
    } mac_state_t;

    mac_state_t st_d, st_q;
    mac_op_e    op;
    logic [DW-1:0] mul_a, mul_b, rd_word;
    logic [PW-1:0] prod;
    logic [AW-1:0] prod_ext, rd_src;
    logic [NACC-1:0][AW-1:0] acc_view;

    assign op       = mac_op_e'(op_i);
    assign prod_ext = {{GW{prod[PW-1]}}, prod};
    assign rd_src   = st_q.acc[acc_sel_i];
    assign acc_view = st_q.acc;
    assign wb_word_o = st_q.wb;

    frac_mul #(.DW(DW)) u_mul (
        .a_i (mul_a),
        .b_i (mul_b),
        .p_o (prod)
    );

    acc_readout #(.DW(DW), .GW(GW)) u_rd (
        .acc_i  (rd_src),
        .word_o (rd_word)
    );

    always_comb begin
        st_d  = st_q;
        mul_a = mem_word_i;
        mul_b = rf_word_i;
        if (op == OP_CONV_B) begin
            mul_a = rf_word_i;
            mul_b = mem_word_i;
        end
        case (op)
            OP_CONV_A, OP_CONV_B: begin
                st_d.acc[acc_sel_i] = st_q.acc[acc_sel_i] + prod_ext;
                st_d.wb             = mem_word_i;
            end
            OP_CLEAR: st_d.acc[acc_sel_i] = '0;
            OP_READ:  st_d.wb             = rd_word;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/twin_acc_mac_chk.sv
module twin_acc_mac_chk #(
    parameter int DW   = 16,
    parameter int GW   = 8,
    parameter int NACC = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [2:0]                       op_i,
    input logic [$clog2(NACC)-1:0]          sel_i,
    input logic [DW-1:0]                    mem_i,
    input logic [DW-1:0]                    wb_i,
    input logic [NACC-1:0][2*DW+GW-1:0]     acc_i
);
    localparam int SW = $clog2(NACC);

    a_r2_conv_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1 || op_i == 3'd2) |=> wb_i == $past(mem_i));

    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3) |=> acc_i[$past(sel_i)] == '0);

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 || op_i > 3'd4) |=> ($stable(acc_i) && $stable(wb_i)));

    a_r7_read_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4) |=> $stable(acc_i));

    a_r11_clear_holds_out: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3) |=> $stable(wb_i));

    for (genvar k = 0; k < NACC; k++) begin : g_other
        a_r5_other_untouched: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_i != SW'(k)) |=> $stable(acc_i[k]));
    end
endmodule

bind twin_acc_mac twin_acc_mac_chk #(.DW(DW), .GW(GW), .NACC(NACC)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op_i),
    .sel_i (acc_sel_i),
    .mem_i (mem_word_i),
    .wb_i  (wb_word_o),
    .acc_i (acc_view)
);

// File: tb/twin_acc_mac_test.sv
module twin_acc_mac_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic        sel = 1'b0;
    logic [15:0] rf = '0;
    logic [15:0] mem = '0;
    logic [15:0] wb;

    int n_run = 0;
    int n_fail = 0;
    logic [39:0] mdl [2];
    logic [15:0] exp_wb;
    logic [15:0] marr [32];

    always #10 clk = ~clk;

    twin_acc_mac uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op_i),
        .acc_sel_i  (sel),
        .rf_word_i  (rf),
        .mem_word_i (mem),
        .wb_word_o  (wb)
    );

    function automatic logic [15:0] ref_read(input logic [39:0] a);
        logic [39:0] s;
        s = a + 40'h00_0000_4000;
        if (s[39:30] == 10'h000 || s[39:30] == 10'h3FF) return s[30:15];
        return s[39] ? 16'h8000 : 16'h7FFF;
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] expv);
        n_run++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, expv);
        end
    endtask

    task automatic issue(input logic [2:0] o, input logic s, input logic [15:0] r, input logic [15:0] m);
        logic signed [31:0] p;
        op_i = o; sel = s; rf = r; mem = m;
        p = $signed(r) * $signed(m);
        case (o)
            3'd1, 3'd2: begin mdl[s] = mdl[s] + {{8{p[31]}}, p}; exp_wb = m; end
            3'd3: mdl[s] = '0;
            3'd4: exp_wb = ref_read(mdl[s]);
            default: ;
        endcase
        @(posedge clk); #1;
        case (o)
            3'd1: chk("R2 convolve A forward", wb, exp_wb);
            3'd2: chk("R6 convolve B forward", wb, exp_wb);
            3'd4: chk("R7 readout value", wb, exp_wb);
            3'd3: chk("R11 clear holds output", wb, exp_wb);
            default: chk("R4 idle holds output", wb, exp_wb);
        endcase
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] r;
        mdl[0] = '0; mdl[1] = '0; exp_wb = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 reset output", wb, 16'h0000);
        issue(3'd4, 1'b0, 16'h0, 16'h0); chk("R1 acc0 zero", wb, 16'h0000);
        issue(3'd4, 1'b1, 16'h0, 16'h0); chk("R1 acc1 zero", wb, 16'h0000);

        // interleaved FIR pairs over several memory patterns
        for (int seed = 0; seed < 4; seed++) begin
            for (int k = 0; k < 32; k++)
                marr[k] = 16'((k * 37 + seed * 1013) ^ (k << 9) ^ (seed * 16'h5A5A));
            issue(3'd3, 1'b0, 16'h0, 16'h0);
            issue(3'd3, 1'b1, 16'h0, 16'h0);
            r = marr[16];
            for (int t = 0; t < 12; t++) begin
                issue(3'd1, 1'b0, r, marr[t]);     r = wb;
                issue(3'd2, 1'b1, r, marr[16 + t]); r = wb;
            end
            issue(3'd4, 1'b0, 16'h0, 16'h0); chk("R8 FIR result 0", wb, ref_read(mdl[0]));
            issue(3'd4, 1'b1, 16'h0, 16'h0); chk("R8 FIR result 1", wb, ref_read(mdl[1]));
            issue(3'd4, 1'b0, 16'h0, 16'h0); chk("R7 readout repeatable", wb, ref_read(mdl[0]));
        end

        // R3/R5: clear one, the other survives
        issue(3'd3, 1'b1, 16'h0, 16'h0);
        issue(3'd4, 1'b1, 16'h0, 16'h0); chk("R3 cleared acc1", wb, 16'h0000);
        issue(3'd4, 1'b0, 16'h0, 16'h0); chk("R5 acc0 kept", wb, ref_read(mdl[0]));

        // R4: idle and unused codes
        for (int c = 0; c < 8; c++) begin
            if (c == 0 || c > 4) begin
                issue(3'(c), 1'b0, 16'h1234, 16'h7777);
                issue(3'(c), 1'b1, 16'h4321, 16'h5555);
            end
        end
        issue(3'd4, 1'b0, 16'h0, 16'h0); chk("R4 acc0 after idle", wb, ref_read(mdl[0]));

        // R8 rounding thresholds (acc = small raw values)
        issue(3'd3, 1'b0, 0, 0); issue(3'd1, 1'b0, 16'h3FFF, 16'h0001);
        issue(3'd4, 1'b0, 0, 0); chk("R8 below half", wb, 16'h0000);
        issue(3'd3, 1'b0, 0, 0); issue(3'd1, 1'b0, 16'h4000, 16'h0001);
        issue(3'd4, 1'b0, 0, 0); chk("R8 half rounds up", wb, 16'h0001);
        issue(3'd3, 1'b0, 0, 0); issue(3'd2, 1'b0, 16'hC000, 16'h0001);
        issue(3'd4, 1'b0, 0, 0); chk("R8 negative half", wb, 16'h0000);
        issue(3'd3, 1'b0, 0, 0); issue(3'd2, 1'b0, 16'hBFFF, 16'h0001);
        issue(3'd4, 1'b0, 0, 0); chk("R8 negative past half", wb, 16'hFFFF);
        issue(3'd3, 1'b1, 0, 0); issue(3'd1, 1'b1, 16'h7FFF, 16'h7FFF);
        issue(3'd4, 1'b1, 0, 0); chk("R8 largest unsaturated", wb, 16'h7FFE);

        // R9 saturation
        issue(3'd2, 1'b1, 16'h7FFF, 16'h7FFF);
        issue(3'd4, 1'b1, 0, 0); chk("R9 positive saturation", wb, 16'h7FFF);
        issue(3'd3, 1'b1, 0, 0);
        issue(3'd1, 1'b1, 16'h8000, 16'h7FFF); issue(3'd2, 1'b1, 16'h7FFF, 16'h8000);
        issue(3'd4, 1'b1, 0, 0); chk("R9 negative saturation", wb, 16'h8000);
        issue(3'd3, 1'b1, 0, 0); issue(3'd1, 1'b1, 16'h8000, 16'h8000);
        issue(3'd4, 1'b1, 0, 0); chk("R9 minus one squared", wb, 16'h7FFF);

        // R10 wrap modulo 2^40
        issue(3'd3, 1'b0, 0, 0);
        for (int i = 0; i < 512; i++) issue(3'd1, 1'b0, 16'h8000, 16'h8000);
        issue(3'd4, 1'b0, 0, 0); chk("R10 wrap to negative", wb, 16'h8000);
        for (int i = 0; i < 512; i++) issue(3'd2, 1'b0, 16'h8000, 16'h8000);
        issue(3'd4, 1'b0, 0, 0); chk("R10 wrap to zero", wb, 16'h0000);
        issue(3'd4, 1'b1, 0, 0); chk("R5 acc1 untouched by wrap run", wb, 16'h7FFF);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule